// File: doc/BRIEF.md
# Framed Serial Result Transmitter

This block takes 12-bit conversion results from the converter's control logic and shifts each one out over a three-wire serial port. The three lines are a serial clock, an active-low framing strobe and a data line. The serial clock is divided down from the converter clock that runs the block. A mode input chooses between two clock behaviours. In free-running mode the serial clock toggles all the time. In gated mode it stays high whenever no word is in flight.

Each line behaves as an open-drain output. The block reports a drive-low enable for each line and the level the line takes with its pull-up, so a released line reads high. Each word goes out MSB first. Data changes only on a rising serial-clock edge, so it is stable when the receiver samples it on the falling edge while the strobe is low. A result that arrives while a frame is in progress is held in a one-deep slot and sent once that frame has ended.

Top module: `serial_result_tx`

## Requirements
- R1: While reset is asserted, and immediately after it, all three drive enables are 0 and all three line levels are 1.
- R2: In gated mode (`free_run_i` = 0) with no frame in progress, the serial clock line stays at 1 and its drive enable stays at 0.
- R3: In free-running mode (`free_run_i` = 1) the serial clock toggles every `HALF_DIV` clock cycles, even when no frame is in progress. With the default `HALF_DIV` = 2 this gives exactly 10 rising edges in any 40 consecutive cycles.
- R4: Each frame holds the strobe low across exactly 12 falling serial-clock edges. The bits sampled on those edges rebuild the word MSB first, and the strobe rises after the twelfth falling edge.
- R5: The strobe falls one half serial-clock period (`HALF_DIV` clock cycles) before the first falling edge of the frame.
- R6: The data line changes only together with a rising serial-clock edge. At every falling edge inside a frame, its level equals the level one clock cycle earlier.
- R7: A result-valid pulse that arrives during a frame is held, and its word is sent in the next frame. The hold slot is one deep, so a newer pulse replaces a word that is still waiting and the replaced word is never sent.
- R8: On every line, the line level is always the inverse of its drive enable. The data line is driven only while the strobe is low.
- R9: In gated mode with the block idle, a result-valid pulse sampled at clock edge k makes the strobe go low at edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Converter clock; the serial clock is derived from it |
| rst_ni | input | 1 | Asynchronous active-low reset |
| free_run_i | input | 1 | 1: free-running serial clock, 0: gated serial clock |
| res_valid_i | input | 1 | One-cycle pulse marking a new result |
| res_word_i | input | 12 | Conversion result, sampled with `res_valid_i` |
| sclk_oe_o | output | 1 | Serial clock drive-low enable |
| sclk_o | output | 1 | Serial clock line level with pull-up |
| strb_oe_o | output | 1 | Strobe drive-low enable |
| strb_n_o | output | 1 | Strobe line level with pull-up, active low |
| sdat_oe_o | output | 1 | Data drive-low enable |
| sdat_o | output | 1 | Data line level with pull-up |

## Verification
A wrong bit counter shows up as soon as the first frame ends. The strobe then spans the wrong number of falling edges, and the rebuilt word no longer matches the scoreboard. A corrupted shift register or an early data update shows at the very next falling edge, either as a wrong bit or as the data line moving at the sampling edge. A lost or extra entry in the hold slot puts every later frame out of step with the expected queue. A stuck serial-clock divider or a gating fault shows within one half period in the idle windows, through a missing or extra edge count.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;
  typedef enum logic {
    CLK_GATED = 1'b0,
    CLK_FREE  = 1'b1
  } clk_mode_e;

  localparam int unsigned LINE_SDAT = 0;
  localparam int unsigned LINE_SCLK = 1;
  localparam int unsigned LINE_STRB = 2;
  localparam int unsigned N_LINES   = 3;
endpackage

// File: rtl/sclk_gen.sv
module sclk_gen #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic free_run_i,
  input  logic busy_i,
  input  logic start_i,
  output logic sclk_o,
  output logic rise_tick_o,
  output logic fall_tick_o
);
  localparam int unsigned CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             sclk_q;
  logic             running;
  logic             tick;

  assign running     = free_run_i | busy_i;
  assign tick        = running & (cnt_q == CNT_W'(HALF_DIV - 1));
  assign rise_tick_o = tick & ~sclk_q;
  assign fall_tick_o = tick & sclk_q;
  assign sclk_o      = sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b1;
    end else begin
      if (start_i || tick || !running) cnt_q <= '0;
      else                             cnt_q <= cnt_q + 1'b1;
      if (!running)  sclk_q <= 1'b1;  // gated idle parks high
      else if (tick) sclk_q <= ~sclk_q;
    end
  end

  a_r2_gated_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!free_run_i && !busy_i) |=> sclk_q);
endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl #(
  parameter int unsigned WORD_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              sclk_i,
  input  logic              rise_tick_i,
  input  logic              fall_tick_i,
  output logic              busy_o,
  output logic              bit_o
);
  localparam int unsigned BITS_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] shreg_q;
  logic [BITS_W-1:0] bits_q;
  logic              busy_q;
  logic              last_bit;

  assign last_bit = (bits_q == BITS_W'(WORD_W));
  assign busy_o   = busy_q;
  assign bit_o    = shreg_q[WORD_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      bits_q  <= '0;
      shreg_q <= '0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      bits_q  <= '0;
      shreg_q <= word_i;
    end else if (busy_q) begin
      if (fall_tick_i) bits_q <= bits_q + 1'b1;
      if (rise_tick_i) begin
        if (last_bit) busy_q  <= 1'b0;
        else          shreg_q <= {shreg_q[WORD_W-2:0], 1'b0};
      end
    end
  end

  a_r4_no_extra_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && fall_tick_i) |-> (bits_q < BITS_W'(WORD_W)));
  a_r4_end_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> sclk_i);
endmodule

// File: rtl/od_pads.sv
module od_pads #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] drive_low_i,
  output logic [N-1:0] oe_o,
  output logic [N-1:0] line_o
);
  for (genvar i = 0; i < N; i++) begin : g_pad
    assign oe_o[i]   = drive_low_i[i];
    assign line_o[i] = drive_low_i[i] ? 1'b0 : 1'b1;  // pulled up when released
  end
endmodule

// File: rtl/serial_result_tx.sv
module serial_result_tx
  import serial_tx_pkg::*;
#(
  parameter int unsigned WORD_W   = 12,
  parameter int unsigned HALF_DIV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              free_run_i,
  input  logic              res_valid_i,
  input  logic [WORD_W-1:0] res_word_i,
  output logic              sclk_oe_o,
  output logic              sclk_o,
  output logic              strb_oe_o,
  output logic              strb_n_o,
  output logic              sdat_oe_o,
  output logic              sdat_o
);
  logic              hold_vld_q;
  logic [WORD_W-1:0] hold_word_q;
  logic              busy, start, sclk_q, rise_tick, fall_tick, tx_bit;
  logic [N_LINES-1:0] drive_low, oe, line;
  clk_mode_e         mode;

  assign mode  = clk_mode_e'(free_run_i);
  assign start = hold_vld_q & ~busy & ((mode == CLK_FREE) ? rise_tick : 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_vld_q  <= 1'b0;
      hold_word_q <= '0;
    end else if (res_valid_i) begin
      hold_vld_q  <= 1'b1;  // newest result wins the single slot
      hold_word_q <= res_word_i;
    end else if (start) begin
      hold_vld_q  <= 1'b0;
    end
  end

  sclk_gen #(.HALF_DIV(HALF_DIV)) u_sclk (
    .clk_i, .rst_ni, .free_run_i, .busy_i(busy), .start_i(start),
    .sclk_o(sclk_q), .rise_tick_o(rise_tick), .fall_tick_o(fall_tick)
  );

  frame_ctrl #(.WORD_W(WORD_W)) u_frame (
    .clk_i, .rst_ni, .start_i(start), .word_i(hold_word_q), .sclk_i(sclk_q),
    .rise_tick_i(rise_tick), .fall_tick_i(fall_tick), .busy_o(busy), .bit_o(tx_bit)
  );

  assign drive_low[LINE_SDAT] = busy & ~tx_bit;
  assign drive_low[LINE_SCLK] = ~sclk_q;
  assign drive_low[LINE_STRB] = busy;

  od_pads #(.N(N_LINES)) u_pads (.drive_low_i(drive_low), .oe_o(oe), .line_o(line));

  assign sdat_oe_o = oe[LINE_SDAT];
  assign sdat_o    = line[LINE_SDAT];
  assign sclk_oe_o = oe[LINE_SCLK];
  assign sclk_o    = line[LINE_SCLK];
  assign strb_oe_o = oe[LINE_STRB];
  assign strb_n_o  = line[LINE_STRB];

  a_r6_data_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy) && !$stable(tx_bit)) |-> $rose(sclk_q));
  a_r8_data_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdat_oe_o |-> !strb_n_o);
  a_r8_od_levels: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o != sclk_oe_o) && (strb_n_o != strb_oe_o) && (sdat_o != sdat_oe_o));
  a_r7_slot_drains: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_vld_q && !busy && !free_run_i && !res_valid_i) |=> (busy && !hold_vld_q));
endmodule

// File: tb/serial_result_tx_tb.sv
module serial_result_tx_tb;
  localparam int unsigned W = 12;
  localparam int unsigned H = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic free_run = 1'b0;
  logic res_valid = 1'b0;
  logic [W-1:0] res_word = '0;
  logic sclk_oe, sclk, strb_oe, strb_n, sdat_oe, sdat;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [W-1:0] exp_q[$];

  always #2.5 clk = ~clk;

  serial_result_tx #(.WORD_W(W), .HALF_DIV(H)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .free_run_i(free_run), .res_valid_i(res_valid),
    .res_word_i(res_word), .sclk_oe_o(sclk_oe), .sclk_o(sclk), .strb_oe_o(strb_oe),
    .strb_n_o(strb_n), .sdat_oe_o(sdat_oe), .sdat_o(sdat)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [W-1:0] w, input bit expect_tx);
    @(negedge clk);
    res_valid = 1'b1;
    res_word  = w;
    if (expect_tx) exp_q.push_back(w);
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0 || strb_n !== 1'b1) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // monitor: rebuild frames on falling serial-clock edges and score them
  logic p_sclk = 1'b1, p_strb = 1'b1, p_sdat = 1'b1;
  logic [W-1:0] rx;
  int nbits, lead, stab_err, od_err;
  always @(negedge clk) begin
    if (rst_ni) begin
      if ((sclk == sclk_oe) || (strb_n == strb_oe) || (sdat == sdat_oe) || (sdat_oe && strb_n))
        od_err++;
      if (!strb_n && p_strb) begin
        nbits = 0; lead = 0; rx = '0; stab_err = 0;
      end
      if (!strb_n) begin
        if (p_sclk && !sclk) begin
          if (nbits == 0) chk(lead == H, "R5 strobe lead", lead, H);
          if (sdat !== p_sdat) stab_err++;
          rx = {rx[W-2:0], sdat};
          nbits++;
        end else if (nbits == 0) begin
          lead++;
        end
      end
      if (strb_n && !p_strb) begin
        chk(nbits == W, "R4 falls per frame", nbits, W);
        chk(stab_err == 0, "R6 data stable at fall", stab_err, 0);
        chk(od_err == 0, "R8 open-drain levels", od_err, 0);
        if (exp_q.size() == 0) chk(1'b0, "R7 unexpected frame", rx, 0);
        else begin
          logic [W-1:0] e;
          e = exp_q.pop_front();
          chk(rx == e, "R4/R7 word", rx, e);
        end
      end
    end
    p_sclk = sclk; p_strb = strb_n; p_sdat = sdat;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({sclk_oe, strb_oe, sdat_oe} == 3'b000, "R1 oe in reset", {sclk_oe, strb_oe, sdat_oe}, 0);
    chk({sclk, strb_n, sdat} == 3'b111, "R1 lines in reset", {sclk, strb_n, sdat}, 7);
    rst_ni = 1'b1;
    @(negedge clk);
    chk({sclk, strb_n, sdat, sclk_oe, strb_oe, sdat_oe} == 6'b111000, "R1 after reset",
        {sclk, strb_n, sdat, sclk_oe, strb_oe, sdat_oe}, 6'b111000);

    // R2: gated idle
    begin
      int hi = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (sclk && !sclk_oe) hi++;
      end
      chk(hi == 20, "R2 gated idle clock high", hi, 20);
    end

    // R9: start latency in gated mode
    @(negedge clk);
    res_valid = 1'b1; res_word = 12'hA5A; exp_q.push_back(12'hA5A);
    @(negedge clk);
    res_valid = 1'b0;
    chk(strb_n == 1'b1, "R9 strobe one edge after pulse", strb_n, 1);
    @(negedge clk);
    chk(strb_n == 1'b0, "R9 strobe two edges after pulse", strb_n, 0);
    wait_idle();

    // gated mode patterns
    send(12'h000, 1'b1); wait_idle();
    send(12'hFFF, 1'b1); wait_idle();
    send(12'h800, 1'b1); wait_idle();
    send(12'h001, 1'b1); wait_idle();
    // R7: held word sent next
    send(12'h5A5, 1'b1);
    send(12'h3C3, 1'b1);
    wait_idle();
    // R7: newer pulse replaces a waiting word
    send(12'h123, 1'b1);
    repeat (6) @(negedge clk);
    send(12'h456, 1'b0);
    send(12'h789, 1'b1);
    wait_idle();
    begin
      int hi = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (sclk) hi++;
      end
      chk(hi == 20, "R2 gated idle after frames", hi, 20);
    end

    // R3: free-running clock when idle
    free_run = 1'b1;
    repeat (8) @(negedge clk);
    begin
      int rises = 0;
      logic pv;
      pv = sclk;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (sclk && !pv) rises++;
        pv = sclk;
      end
      chk(rises == 40 / (2 * H), "R3 free-run edges", rises, 40 / (2 * H));
    end
    send(12'hC35, 1'b1);
    send(12'h7FE, 1'b1);
    wait_idle();
    send(12'h001, 1'b1); wait_idle();
    send(12'hFFE, 1'b1); wait_idle();

    chk(exp_q.size() == 0, "R7 queue drained", exp_q.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule